// File: doc/BRIEF.md
# Caliper Serial Frame Receiver

This block takes the two-wire measurement stream of an inexpensive digital caliper and turns it into parallel data words inside the system clock domain. The caliper drives a slow clock line and a data line, both unrelated to the system clock. Each caliper clock period carries one bit, and a frame is made of two words of `WORD_BITS` bits, which gives 48 bits at the default setting. The data line changes a short time after each caliper clock rise. For a zero bit it can also flash high briefly before it settles low, so the receiver takes each bit on the caliper clock fall, when the line has long been stable.

Both lines pass through two-stage synchronisers. Once the final bit of a frame has been taken, both words are presented together and a one-cycle strobe marks them. Frames can be separated by gaps of any length. An idle timer measures how long the synchronised caliper clock has gone without an edge. If that time reaches the programmable limit while a frame is only partly received, the partial frame is dropped and a one-cycle error strobe is raised.

Top module: `caliper_rx`

## Requirements
- R1: After reset, `word_a` and `word_b` are zero and `frame_valid` and `frame_short` are low.
- R2: Each line passes through a two-flop synchroniser. A bit is taken only on a falling edge of the synchronised caliper clock. A high pulse on the data line that ends before that fall has no effect on the decoded value.
- R3: Bit order: the first bit received in a frame goes to `word_a[0]`. Bit k (counting from 0) goes to `word_a[k]` for k < WORD_BITS and to `word_b[k-WORD_BITS]` for the rest.
- R4: After the falling edge that carries the last bit of a frame, `frame_valid` is high for exactly one cycle, and both words are updated in that same cycle.
- R5: Between strobes, `word_a` and `word_b` keep their values.
- R6: A partial frame is dropped when the synchronised caliper clock shows no edge for `idle_limit` cycles. `frame_short` then pulses for one cycle, `frame_valid` stays low, and the next frame decodes correctly from its first bit.
- R7: An idle gap of any length after a complete frame raises no `frame_short`.
- R8: `frame_valid` and `frame_short` are never high together, and the internal bit count never reaches the frame length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| cal_clk | input | 1 | Caliper clock line, asynchronous |
| cal_data | input | 1 | Caliper data line, asynchronous |
| idle_limit | input | IDLE_W | Number of cycles without a clock edge after which a partial frame is dropped |
| word_a | output | WORD_BITS | First word of the last complete frame |
| word_b | output | WORD_BITS | Second word of the last complete frame |
| frame_valid | output | 1 | One-cycle strobe: new words present |
| frame_short | output | 1 | One-cycle strobe: a partial frame was dropped |

## Verification
A bit count that has slipped out of step with the frame shows up on the very next frame. The words come out shifted, or the strobe appears a bit early or late, and a count left over after a timeout corrupts the frame that follows. A data sample taken at the wrong edge turns glitched zeros into ones within a single frame. An idle timer that never fires, or fires with no partial frame pending, is seen within `idle_limit` cycles as a missing or spurious `frame_short`.

// File: rtl/caliper_rx.sv
module caliper_rx #(
  parameter int WORD_BITS = 24,
  parameter int IDLE_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_clk,
  input  logic                 cal_data,
  input  logic [IDLE_W-1:0]    idle_limit,
  output logic [WORD_BITS-1:0] word_a,
  output logic [WORD_BITS-1:0] word_b,
  output logic                 frame_valid,
  output logic                 frame_short
);
  localparam int FRAME_BITS = 2 * WORD_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic [1:0]            ck_sync, dt_sync;
  logic                  ck_prev;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      cnt;
  logic [IDLE_W-1:0]     idle_cnt;

  wire                  ck       = ck_sync[1];
  wire                  fall     = ck_prev & ~ck;
  wire                  edge_hit = ck_prev ^ ck;
  wire                  last_bit = fall && (cnt == CNT_W'(FRAME_BITS - 1));
  wire                  timeout  = !edge_hit && (idle_cnt >= idle_limit) && (cnt != '0);
  wire [FRAME_BITS-1:0] next_sh  = {dt_sync[1], shreg[FRAME_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sync     <= '0;
      dt_sync     <= '0;
      ck_prev     <= 1'b0;
      shreg       <= '0;
      cnt         <= '0;
      idle_cnt    <= '0;
      word_a      <= '0;
      word_b      <= '0;
      frame_valid <= 1'b0;
      frame_short <= 1'b0;
    end else begin
      ck_sync     <= {ck_sync[0], cal_clk};
      dt_sync     <= {dt_sync[0], cal_data};
      ck_prev     <= ck;
      frame_valid <= last_bit;
      frame_short <= timeout;

      if (edge_hit)
        idle_cnt <= '0;
      else if (idle_cnt < idle_limit)
        idle_cnt <= idle_cnt + 1'b1;

      if (fall) begin
        shreg <= next_sh;
        cnt   <= last_bit ? '0 : cnt + 1'b1;
      end else if (timeout) begin
        cnt <= '0;
      end

      if (last_bit) begin
        word_a <= next_sh[WORD_BITS-1:0];
        word_b <= next_sh[FRAME_BITS-1:WORD_BITS];
      end
    end
  end

  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r2_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(fall));

  a_r5_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(word_a) && $stable(word_b)));

  a_r6_short_needs_partial: assert property (@(posedge clk) disable iff (!rst_n)
    frame_short |-> ($past(cnt) != '0 && cnt == '0));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && frame_short));

  a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(FRAME_BITS));
endmodule

// File: tb/sim_caliper_rx.sv
`timescale 1ns/1ps
module sim_caliper_rx;
  localparam int WB = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_clk = 1'b0;
  logic          cal_data = 1'b0;
  logic [15:0]   idle_limit = 16'd40;
  logic [WB-1:0] word_a, word_b;
  logic          frame_valid, frame_short;

  int n_checks = 0;
  int n_fail   = 0;
  int vcount, scount;
  logic [WB-1:0] cap_a, cap_b;

  always #2.5 clk = ~clk;

  caliper_rx #(.WORD_BITS(WB), .IDLE_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_clk(cal_clk), .cal_data(cal_data),
    .idle_limit(idle_limit), .word_a(word_a), .word_b(word_b),
    .frame_valid(frame_valid), .frame_short(frame_short));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [2*WB-1:0] bits, input int nbits, input bit glitch);
    for (int i = 0; i < nbits; i++) begin
      cal_clk = 1'b1;
      wait_cyc(2);
      if (glitch && !bits[i]) begin
        cal_data = 1'b1;
        wait_cyc(3);
        cal_data = 1'b0;
      end else begin
        cal_data = bits[i];
        wait_cyc(3);
      end
      wait_cyc(5);
      cal_clk = 1'b0;
      wait_cyc(8);
    end
    cal_data = 1'b0;
  endtask

  task automatic observe(input int n);
    vcount = 0;
    scount = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (frame_valid) begin
        vcount++;
        cap_a = word_a;
        cap_b = word_b;
      end
      if (frame_short) scount++;
    end
  endtask

  task automatic full_frame(input string req, input logic [WB-1:0] a, input logic [WB-1:0] b, input bit glitch);
    fork
      send_bits({b, a}, 2 * WB, glitch);
      observe(2 * WB * 18 + 30);
    join
    check({req, " valid pulse count"}, vcount, 1);
    check({req, " short count"}, scount, 0);
    check({req, " word_a"}, cap_a, a);
    check({req, " word_b"}, cap_b, b);
  endtask

  task automatic t_reset;
    wait_cyc(1);
    check("R1 word_a", word_a, 0);
    check("R1 word_b", word_b, 0);
    check("R1 valid", frame_valid, 0);
    check("R1 short", frame_short, 0);
  endtask

  task automatic t_order;
    full_frame("R3 order", 24'h000001, 24'h800000, 1'b0);
    full_frame("R4 pattern", 24'h5A3C96, 24'hC3E1F0, 1'b0);
  endtask

  task automatic t_glitch;
    full_frame("R2 glitch", 24'h0F0F0F, 24'h00A005, 1'b1);
    full_frame("R2 all zero", 24'h000000, 24'h000000, 1'b1);
  endtask

  task automatic t_hold;
    logic [WB-1:0] ha, hb;
    ha = word_a;
    hb = word_b;
    cal_data = 1'b1;
    observe(30);
    cal_data = 1'b0;
    check("R5 hold word_a", word_a, ha);
    check("R5 hold word_b", word_b, hb);
    check("R5 no valid", vcount, 0);
    check("R7 no short in gap", scount, 0);
  endtask

  task automatic t_short;
    fork
      send_bits(48'h0000_0000_03FF, 10, 1'b0);
      observe(10 * 18 + 60);
    join
    check("R6 short pulse", scount, 1);
    check("R6 no valid", vcount, 0);
    full_frame("R6 recovery", 24'hABCDEF, 24'h123456, 1'b0);
  endtask

  task automatic t_gap;
    observe(300);
    check("R7 long gap short", scount, 0);
    check("R7 long gap valid", vcount, 0);
    full_frame("R7 after gap", 24'hFFFFFF, 24'h000001, 1'b1);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_glitch();
    t_hold();
    t_short();
    t_gap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule